// File: doc/BRIEF.md
# Descriptor ring producer with pass-count stamping

This block is the producing side of a circular descriptor ring held in on-chip memory. Upstream logic offers fixed-size descriptors over a valid/ready push port. The block writes each accepted descriptor as one 256-bit memory word at its head index. It keeps the head index itself, and it compares that index with a tail index supplied by the consumer to report when the ring is full or empty.

Into the top word of every entry the block writes two stamps of its own. One is a configured 8-bit ring identifier. The other is a 4-bit count of how many passes the producer has started through the ring. Both replace whatever the upstream word holds in those bit positions.

A consumer that remembers which pass it expects can find the fresh entries by reading the lowest bit of the pass count. That bit flips on every pass at every index, so the consumer never has to fetch the head index.

Top module: `desc_ring_producer`

## Requirements
- R1: After reset the ring reports empty (with tail 0), not full, push_ready high, and no memory write happens while push_valid is low.
- R2: On a push handshake (push_valid and push_ready both high) mem_we is high in that same cycle. mem_wdata[223:0] equals push_data, and mem_wdata[243:224] equals push_word7[19:0].
- R3: mem_wdata[251:244] (bits 27:20 of entry word 7) always carries cfg_ring_id, whatever push_word7[31:20] holds.
- R4: mem_wdata[255:252] (bits 31:28 of entry word 7) carries the pass count. The count is 0 out of reset, and every entry of the first pass through the ring is stamped 1.
- R5: The pass count steps by one exactly when an entry is written at index 0, so the wrap of the head from RING_DEPTH-1 to 0 starts a new pass. All entries of one pass carry the same count.
- R6: After a pass stamped 15, the next pass is stamped 0.
- R7: mem_addr equals the head index. The head starts at 0, moves by one only on a handshake, and wraps from RING_DEPTH-1 to 0.
- R8: ring_full is high when advancing the head would make it equal to cons_tail. While it is high, push_ready is low and a push_valid causes no memory write and no head movement.
- R9: ring_empty is high exactly when the head equals cons_tail.
- R10: For any index, bit 252 of the entry written there differs from bit 252 of the previous entry written at that same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_ring_id | input | 8 | Ring identifier stamped into every entry |
| push_valid | input | 1 | Upstream offers a descriptor |
| push_ready | output | 1 | Block can accept a descriptor (ring not full) |
| push_data | input | 224 | Entry words 0 to 6 |
| push_word7 | input | 32 | Entry word 7; bits 31:20 are replaced by the stamps |
| cons_tail | input | IDX_W | Consumer's tail index |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | IDX_W | Memory write index (head) |
| mem_wdata | output | 256 | Stamped entry |
| ring_full | output | 1 | Ring full |
| ring_empty | output | 1 | Ring empty |

## Verification
A wrong head index shows on mem_addr at the very next write. If the head only drifts, full and empty also disagree with the consumer's tail, and that is seen in the first cycle after the drift. A pass count that steps at the wrong time, or that misses its rollover from 15 to 0, shows in the top stamp bits of the next write. For the phase bit this means the next write at index 0; for the count itself it means every write in the new pass. The bench therefore checks the stamp of every entry across more than sixteen passes and compares each entry's phase bit with the one last written at the same index.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
  localparam int WORD_W      = 32;
  localparam int ENTRY_WORDS = 8;
  localparam int ENTRY_W     = WORD_W * ENTRY_WORDS;
  localparam int PAYLOAD_W   = WORD_W * (ENTRY_WORDS - 1);
  localparam int ID_W        = 8;
  localparam int LOOP_W      = 4;
  localparam int W7_LOW_W    = WORD_W - ID_W - LOOP_W;
endpackage

// File: rtl/ring_rst_sync.sv
module ring_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/ring_head_ctrl.sv
module ring_head_ctrl #(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [IDX_W-1:0] tail,
  output logic [IDX_W-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] head_q;
  logic [IDX_W-1:0] head_step;

  always_comb begin
    head_step = (head_q == LAST) ? '0 : head_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       head_q <= '0;
    else if (advance) head_q <= head_step;
  end

  assign head  = head_q;
  assign full  = (head_step == tail);
  assign empty = (head_q == tail);

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(head_q)); // R7
  AST_HEAD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && head_q == LAST) |=> (head_q == '0)); // R7
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R8
endmodule

// File: rtl/ring_loop_ctr.sv
module ring_loop_ctr #(
  parameter int LOOP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bump,
  output logic [LOOP_W-1:0] stamp
);
  logic [LOOP_W-1:0] loop_q;
  logic [LOOP_W-1:0] loop_inc;

  always_comb begin
    loop_inc = loop_q + {{(LOOP_W-1){1'b0}}, 1'b1};
    stamp    = bump ? loop_inc : loop_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    loop_q <= '0;
    else if (bump) loop_q <= loop_inc;
  end

  AST_LOOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bump |=> $stable(loop_q)); // R5
  AST_LOOP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    bump |=> !$stable(loop_q)); // R5
endmodule

// File: rtl/ring_entry_stamp.sv
module ring_entry_stamp
  import desc_ring_pkg::*;
(
  input  logic [PAYLOAD_W-1:0] payload,
  input  logic [WORD_W-1:0]    word7_in,
  input  logic [ID_W-1:0]      ring_id,
  input  logic [LOOP_W-1:0]    loop_cnt,
  output logic [ENTRY_W-1:0]   entry
);
  always_comb begin
    entry = {loop_cnt, ring_id, word7_in[W7_LOW_W-1:0], payload};
  end
endmodule

// File: rtl/desc_ring_producer.sv
module desc_ring_producer
  import desc_ring_pkg::*;
#(
  parameter int RING_DEPTH = 8,
  parameter int IDX_W      = $clog2(RING_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ID_W-1:0]      cfg_ring_id,
  input  logic                 push_valid,
  output logic                 push_ready,
  input  logic [PAYLOAD_W-1:0] push_data,
  input  logic [WORD_W-1:0]    push_word7,
  input  logic [IDX_W-1:0]     cons_tail,
  output logic                 mem_we,
  output logic [IDX_W-1:0]     mem_addr,
  output logic [ENTRY_W-1:0]   mem_wdata,
  output logic                 ring_full,
  output logic                 ring_empty
);
  logic              rst_n_s;
  logic              accept;
  logic              at_zero;
  logic [IDX_W-1:0]  head;
  logic              full;
  logic              empty;
  logic [LOOP_W-1:0] loop_stamp;

  ring_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  assign accept  = push_valid && !full;
  assign at_zero = (head == '0);

  ring_head_ctrl #(.DEPTH(RING_DEPTH), .IDX_W(IDX_W)) u_head (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .advance (accept),
    .tail    (cons_tail),
    .head    (head),
    .full    (full),
    .empty   (empty)
  );

  ring_loop_ctr #(.LOOP_W(LOOP_W)) u_loop (
    .clk   (clk),
    .rst_n (rst_n_s),
    .bump  (accept && at_zero),
    .stamp (loop_stamp)
  );

  ring_entry_stamp u_stamp (
    .payload  (push_data),
    .word7_in (push_word7),
    .ring_id  (cfg_ring_id),
    .loop_cnt (loop_stamp),
    .entry    (mem_wdata)
  );

  assign push_ready = !full;
  assign mem_we     = accept;
  assign mem_addr   = head;
  assign ring_full  = full;
  assign ring_empty = empty;

  AST_STAMP_ID: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_we |-> (mem_wdata[ENTRY_W-LOOP_W-1 -: ID_W] == cfg_ring_id)); // R3
  AST_PAYLOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_we |-> (mem_wdata[PAYLOAD_W-1:0] == push_data)); // R2
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    !push_valid |-> !mem_we); // R1
endmodule

// File: tb/desc_ring_producer_bench.sv
module desc_ring_producer_bench;
  localparam int DEPTH = 8;
  localparam int IW    = $clog2(DEPTH);

  logic          clk;
  logic          rst_n;
  logic [7:0]    cfg_ring_id;
  logic          push_valid;
  logic          push_ready;
  logic [223:0]  push_data;
  logic [31:0]   push_word7;
  logic [IW-1:0] cons_tail;
  logic          mem_we;
  logic [IW-1:0] mem_addr;
  logic [255:0]  mem_wdata;
  logic          ring_full;
  logic          ring_empty;

  int vectors;
  int miscompares;

  int          m_head;
  int          m_tail;
  int          m_loop;
  bit          seen  [DEPTH];
  bit          phase [DEPTH];

  desc_ring_producer #(.RING_DEPTH(DEPTH)) u_desc_ring_producer (
    .clk(clk), .rst_n(rst_n), .cfg_ring_id(cfg_ring_id),
    .push_valid(push_valid), .push_ready(push_ready),
    .push_data(push_data), .push_word7(push_word7),
    .cons_tail(cons_tail), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .ring_full(ring_full), .ring_empty(ring_empty)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int nxt(input int i);
    return (i == DEPTH - 1) ? 0 : i + 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit drain);
    logic [223:0] d;
    logic [31:0]  w7;
    int  en;
    bit  ef;
    bit  hs;
    int  el;
    string lt;
    @(negedge clk);
    for (int i = 0; i < 7; i++) d[i*32 +: 32] = $urandom();
    w7 = $urandom();
    push_valid = v;
    push_data  = d;
    push_word7 = w7;
    cons_tail  = IW'(m_tail);
    #2;
    en = nxt(m_head);
    ef = (en == m_tail);
    chk(push_ready == !ef, "R8 ready", push_ready, !ef);
    chk(ring_full == ef, "R8 full", ring_full, ef);
    chk(ring_empty == (m_head == m_tail), "R9 empty", ring_empty, m_head == m_tail);
    hs = v && !ef;
    chk(mem_we == hs, (v && ef) ? "R8 write while full" : "R2 write enable", mem_we, hs);
    el = m_loop;
    if (hs) begin
      el = (m_head == 0) ? (m_loop + 1) % 16 : m_loop;
      chk(mem_addr == IW'(m_head), "R7 addr", mem_addr, m_head);
      chk(mem_wdata[223:0] == d, "R2 payload", mem_wdata[63:0], d[63:0]);
      chk(mem_wdata[243:224] == w7[19:0], "R2 word7 low", mem_wdata[243:224], w7[19:0]);
      chk(mem_wdata[251:244] == cfg_ring_id, "R3 ring id", mem_wdata[251:244], cfg_ring_id);
      if (m_head == 0 && m_loop == 15) lt = "R6 loop rollover";
      else if (el == 1)                lt = "R4 loop first pass";
      else                             lt = "R5 loop count";
      chk(mem_wdata[255:252] == 4'(el), lt, mem_wdata[255:252], el);
      if (seen[m_head])
        chk(mem_wdata[252] != phase[m_head], "R10 phase flip", mem_wdata[252], !phase[m_head]);
    end
    @(posedge clk);
    if (drain && m_tail != m_head) m_tail = nxt(m_tail);
    if (hs) begin
      m_loop = el;
      seen[m_head]  = 1'b1;
      phase[m_head] = el[0];
      m_head = en;
    end
  endtask

  initial begin
    #(20 * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    vectors = 0; miscompares = 0;
    m_head = 0; m_tail = 0; m_loop = 0;
    for (int i = 0; i < DEPTH; i++) begin seen[i] = 1'b0; phase[i] = 1'b0; end
    rst_n = 1'b0; cfg_ring_id = 8'h5a; push_valid = 1'b0;
    push_data = '0; push_word7 = '0; cons_tail = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    // R1 reset state
    chk(push_ready == 1'b1, "R1 ready", push_ready, 1);
    chk(ring_empty == 1'b1, "R1 empty", ring_empty, 1);
    chk(ring_full == 1'b0, "R1 full", ring_full, 0);
    chk(mem_we == 1'b0, "R1 no write", mem_we, 0);
    // fill with tail held, then push against a full ring (R8)
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0);
    // drain fully, pushes idle (R1, R9)
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1);
    // streaming sweep over many passes, rollover (R6)
    cfg_ring_id = 8'ha3;
    for (int i = 0; i < 300; i++) step(1'b1, 1'b1);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      if (i % 500 == 0) cfg_ring_id = 8'($urandom());
      step(($urandom() % 4) != 0, ($urandom() % 5) < 3);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule